// File: doc/BRIEF.md
# Serial Configuration Loader

This block acts as the configuration master for a target FPGA whose configuration port takes one bit per clock. A host hands it a byte count and a start pulse, then streams the bitstream bytes over a valid/ready channel. The loader resets the target through a program/init handshake, shifts every byte out on a single data line with the most significant bit first, and watches the target's init and done pins. It reports how the load ended: success, checksum fault, or timeout.

Each wait on the target has its own timeout, counted in system clock cycles from the moment that wait begins. Every pin step is stretched by a configurable number of cycles, so the configuration clock can run well below the system clock. Once the last byte is out, the loader holds the data line high and keeps toggling the configuration clock until the target raises done. A request to read the configuration back is refused at once, because this port cannot do readback.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, tgt_prog, tgt_cclk, tgt_din, busy, in_ready, load_end, load_ok, crc_err, timeout_err and dump_nak are all 0.
- R2: A start pulse seen while idle raises tgt_prog on the next cycle. tgt_prog stays high until tgt_init is sampled high, then for STEP_CYC more cycles, and then drops. A start pulse seen while busy has no effect.
- R3: The block gives up if tgt_init has not risen within TO_CYC cycles of asserting program, if tgt_init has not fallen within TO_CYC cycles of releasing program, or if tgt_done has not risen within TO_CYC cycles of entering the trailing phase. Giving up sets timeout_err, pulses load_end and drives tgt_prog and tgt_cclk low.
- R4: No byte is accepted and no configuration clock edge occurs until tgt_init has been sampled low after program is released.
- R5: Each accepted byte goes out bit 7 first. Each bit takes three steps of STEP_CYC cycles: the clock low with the previous data, the clock low with the new bit, and the clock high with the bit held.
- R6: in_ready is high only while the block is between bytes, bytes are still owed, and there is no checksum fault. A byte is taken on a clock edge where in_valid and in_ready are both high.
- R7: When a byte is due, and tgt_done is low while tgt_init is high, the block stops. It sets crc_err, pulses load_end, and produces no further configuration clock edges.
- R8: After the last byte, tgt_din is 1 and tgt_cclk toggles every STEP_CYC cycles until tgt_done is sampled high. That ends the load with load_ok.
- R9: dump_req is answered by dump_nak exactly one cycle later in any state, and the target pins are not touched.
- R10: load_end is high for exactly one cycle per load. At most one of load_ok, crc_err and timeout_err is set, and it holds until the next accepted start clears all three.
- R11: A load with byte_count 0 goes from the program handshake straight to the trailing phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (sampled while idle) |
| byte_count | input | CNT_W | Number of bytes in the load, captured at start |
| dump_req | input | 1 | Readback request, always refused |
| in_data | input | DATA_W | Bitstream byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block takes the byte on this edge if valid |
| tgt_init | input | 1 | Target init pin, 1 = asserted |
| tgt_done | input | 1 | Target done pin, 1 = configured |
| tgt_prog | output | 1 | Target program pin, 1 = asserted |
| tgt_cclk | output | 1 | Configuration clock to target |
| tgt_din | output | 1 | Serial configuration data to target |
| busy | output | 1 | A load is in progress |
| load_end | output | 1 | One-cycle pulse when a load finishes |
| load_ok | output | 1 | Last load completed with done high |
| crc_err | output | 1 | Last load stopped on a checksum fault |
| timeout_err | output | 1 | Last load stopped on a wait timeout |
| dump_nak | output | 1 | Readback refusal, one cycle after dump_req |

## Verification
The assertions assume that the target pins and in_valid change only between clock edges and that start and dump_req are single-cycle pulses. They also assume that the target raises init only after the program pulse has begun. The bench drives every input shortly after a rising edge. Its target emulation raises and drops init in step with the observed program pin and asserts the checksum fault condition only between handshakes. The data stream is offered both with and without gaps in in_valid.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_HOLD,
    ST_RELEASE,
    ST_NEXT,
    ST_BLO,
    ST_BDAT,
    ST_BHI,
    ST_TRAIL,
    ST_END
  } ld_state_t;

  // target flags a checksum problem by asserting init before done
  function automatic logic crc_fault(input logic done_pin, input logic init_pin);
    return (!done_pin) && init_pin;
  endfunction

endpackage

// File: rtl/cfgld_count.sv
module cfgld_count #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign hit = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              present,
  input  logic              hold_high,
  output logic              dout,
  output logic              last
);
  localparam int IW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sreg;
  logic [IW-1:0]     idx;

  function automatic logic [DATA_W-1:0] drop_msb(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], 1'b0};
  endfunction

  assign last = (idx == IW'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      idx  <= '0;
      dout <= 1'b0;
    end else if (clr) begin
      idx  <= '0;
      dout <= 1'b0;
    end else if (hold_high) begin
      dout <= 1'b1;
    end else if (load) begin
      sreg <= data_in;
      idx  <= '0;
    end else if (present) begin
      dout <= sreg[DATA_W-1];
      sreg <= drop_msb(sreg);
      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int TO_CYC   = 2500000,
  parameter int STEP_CYC = 2,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              dump_req,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              tgt_init,
  input  logic              tgt_done,
  output logic              tgt_prog,
  output logic              tgt_cclk,
  output logic              tgt_din,
  output logic              busy,
  output logic              load_end,
  output logic              load_ok,
  output logic              crc_err,
  output logic              timeout_err,
  output logic              dump_nak
);

  ld_state_t        st_q, st_d;
  logic [CNT_W-1:0] rem_q;
  logic             ph_q;

  // named internal events
  logic start_acc, accept, fault_now, wait_hit, step_hit, bit_last;
  logic to_hit, crc_hit, ok_hit, state_chg, owed;

  assign owed      = (rem_q != '0);
  assign fault_now = crc_fault(tgt_done, tgt_init);
  assign start_acc = (st_q == ST_IDLE) && start;
  assign in_ready  = (st_q == ST_NEXT) && owed && !fault_now;
  assign accept    = in_ready && in_valid;

  always_comb begin
    st_d    = st_q;
    to_hit  = 1'b0;
    crc_hit = 1'b0;
    ok_hit  = 1'b0;
    unique case (st_q)
      ST_IDLE:    if (start) st_d = ST_CLEAR;
      ST_CLEAR:   if (tgt_init) st_d = ST_HOLD;
                  else if (wait_hit) to_hit = 1'b1;
      ST_HOLD:    if (step_hit) st_d = ST_RELEASE;
      ST_RELEASE: if (!tgt_init) st_d = ST_NEXT;
                  else if (wait_hit) to_hit = 1'b1;
      ST_NEXT:    if (!owed) st_d = ST_TRAIL;
                  else if (fault_now) crc_hit = 1'b1;
                  else if (in_valid) st_d = ST_BLO;
      ST_BLO:     if (step_hit) st_d = ST_BDAT;
      ST_BDAT:    if (step_hit) st_d = ST_BHI;
      ST_BHI:     if (step_hit) st_d = bit_last ? ST_NEXT : ST_BLO;
      ST_TRAIL:   if (tgt_done) ok_hit = 1'b1;
                  else if (wait_hit) to_hit = 1'b1;
      ST_END:     st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
    if (to_hit || crc_hit || ok_hit) st_d = ST_END;
  end

  assign state_chg = (st_d != st_q);

  cfgld_count #(.LIMIT(TO_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(state_chg),
    .en(st_q inside {ST_CLEAR, ST_RELEASE, ST_TRAIL}),
    .hit(wait_hit)
  );

  cfgld_count #(.LIMIT(STEP_CYC)) u_step (
    .clk(clk), .rst_n(rst_n),
    .clr(state_chg || ((st_q == ST_TRAIL) && step_hit)),
    .en(st_q inside {ST_HOLD, ST_BLO, ST_BDAT, ST_BHI, ST_TRAIL}),
    .hit(step_hit)
  );

  cfgld_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .load(accept),
    .data_in(in_data),
    .present((st_q == ST_BLO) && step_hit),
    .hold_high((st_q == ST_NEXT) && !owed),
    .dout(tgt_din), .last(bit_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rem_q       <= '0;
      ph_q        <= 1'b0;
      load_ok     <= 1'b0;
      crc_err     <= 1'b0;
      timeout_err <= 1'b0;
      dump_nak    <= 1'b0;
    end else begin
      st_q     <= st_d;
      dump_nak <= dump_req;
      if (st_q != ST_TRAIL) ph_q <= 1'b0;
      else if (step_hit)    ph_q <= ~ph_q;
      if (start_acc)   rem_q <= byte_count;
      else if (accept) rem_q <= rem_q - 1'b1;
      if (start_acc) begin
        load_ok     <= 1'b0;
        crc_err     <= 1'b0;
        timeout_err <= 1'b0;
      end else begin
        if (ok_hit)  load_ok     <= 1'b1;
        if (crc_hit) crc_err     <= 1'b1;
        if (to_hit)  timeout_err <= 1'b1;
      end
    end
  end

  assign tgt_prog = (st_q == ST_CLEAR) || (st_q == ST_HOLD);
  assign tgt_cclk = (st_q == ST_BHI) || ((st_q == ST_TRAIL) && ph_q);
  assign busy     = (st_q != ST_IDLE);
  assign load_end = (st_q == ST_END);

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!tgt_cclk && !tgt_prog));

  assert_crc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> $past(!tgt_done && tgt_init));

  assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_cclk) |-> $stable(tgt_din));

  assert_end_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> !load_end);

  assert_one_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({load_ok, crc_err, timeout_err}) <= 1);

  assert_dump_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dump_req |=> dump_nak);

  assert_timeout_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (load_end && !tgt_prog));

endmodule

// File: tb/serial_cfg_loader_test.sv
`timescale 1ns/1ps
module serial_cfg_loader_test;
  localparam int TO   = 40;
  localparam int STEP = 2;
  localparam int CW   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, dump_req = 0, in_valid = 0, tgt_init = 0, tgt_done = 0;
  logic [CW-1:0] byte_count = '0;
  logic [7:0] in_data = '0;
  logic in_ready, tgt_prog, tgt_cclk, tgt_din, busy, load_end, load_ok, crc_err, timeout_err, dump_nak;

  int total = 0, bad = 0;
  string cur_tag = "R1";
  bit checking = 0;

  serial_cfg_loader #(.TO_CYC(TO), .STEP_CYC(STEP), .CNT_W(CW), .DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count), .dump_req(dump_req),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .tgt_init(tgt_init),
    .tgt_done(tgt_done), .tgt_prog(tgt_prog), .tgt_cclk(tgt_cclk), .tgt_din(tgt_din),
    .busy(busy), .load_end(load_end), .load_ok(load_ok), .crc_err(crc_err),
    .timeout_err(timeout_err), .dump_nak(dump_nak));

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic e_prog = 0, e_cclk = 0, e_dout = 0, e_busy = 0, e_end = 0;
  logic e_ok = 0, e_crc = 0, e_to = 0, e_rdy = 0, e_nak = 0;

  task automatic m_finish(input logic ok, input logic crc, input logic to);
    e_prog = 0; e_cclk = 0; e_rdy = 0; e_end = 1; e_ok = ok; e_crc = crc; e_to = to;
    @(posedge clk);
    e_end = 0; e_busy = 0;
  endtask

  task automatic m_load(input int count);
    int rem, n, s;
    logic [7:0] b;
    rem = count;
    e_busy = 1; e_prog = 1; e_cclk = 0; e_dout = 0; e_ok = 0; e_crc = 0; e_to = 0;
    n = 0;
    forever begin
      @(posedge clk);
      if (tgt_init) break;
      if (n == TO - 1) begin m_finish(0, 0, 1); return; end
      n++;
    end
    repeat (STEP) @(posedge clk);
    e_prog = 0;
    n = 0;
    forever begin
      @(posedge clk);
      if (!tgt_init) break;
      if (n == TO - 1) begin m_finish(0, 0, 1); return; end
      n++;
    end
    forever begin
      e_rdy = (rem != 0);
      @(posedge clk);
      if (rem == 0) break;
      if (!tgt_done && tgt_init) begin m_finish(0, 1, 0); return; end
      if (in_valid) begin
        b = in_data; rem--; e_rdy = 0;
        for (int i = 7; i >= 0; i--) begin
          repeat (STEP) @(posedge clk);
          e_dout = b[i];
          repeat (STEP) @(posedge clk);
          e_cclk = 1;
          repeat (STEP) @(posedge clk);
          e_cclk = 0;
        end
      end
    end
    e_rdy = 0; e_dout = 1; n = 0; s = 0;
    forever begin
      @(posedge clk);
      if (tgt_done) begin m_finish(1, 0, 0); return; end
      if (n == TO - 1) begin m_finish(0, 0, 1); return; end
      n++;
      if (s == STEP - 1) begin e_cclk = !e_cclk; s = 0; end
      else s++;
    end
  endtask

  initial begin : model
    forever begin
      @(posedge clk);
      if (rst_n && start) m_load(int'(byte_count));
    end
  end

  always @(posedge clk) e_nak <= rst_n && dump_req;

  // ---------------- per-cycle compare and monitors ----------------
  logic s_prog = 0, s_end = 0, prev_cclk = 0;
  int rise_cnt = 0, collect_n = 0, acc_cnt = 0;
  logic hs = 0;
  bit bitq[$];

  always @(negedge clk) begin
    if (checking) begin
      chk(cur_tag, "tgt_prog", tgt_prog, e_prog);
      chk(cur_tag, "tgt_cclk", tgt_cclk, e_cclk);
      chk(cur_tag, "tgt_din", tgt_din, e_dout);
      chk(cur_tag, "busy", busy, e_busy);
      chk(cur_tag, "in_ready", in_ready, e_rdy && !(!tgt_done && tgt_init));
      chk(cur_tag, "load_end", load_end, e_end);
      chk(cur_tag, "status", {load_ok, crc_err, timeout_err}, {e_ok, e_crc, e_to});
      chk("R9", "dump_nak", dump_nak, e_nak);
    end
    s_prog = tgt_prog;
    s_end  = load_end;
    hs     = in_valid && in_ready;
    if (tgt_cclk && !prev_cclk) begin
      rise_cnt++;
      if (rise_cnt <= 8 * collect_n) bitq.push_back(tgt_din);
    end
    prev_cclk = tgt_cclk;
  end

  // ---------------- byte feeder ----------------
  logic [7:0] fq[$];
  bit gappy = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    if (hs && fq.size() > 0) begin void'(fq.pop_front()); acc_cnt++; end
    in_valid = (fq.size() > 0) && !(gappy && (cyc % 3 == 1));
    in_data  = (fq.size() > 0) ? fq[0] : 8'h00;
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29 + i * 71 + 60) & 255);
  endfunction

  // init_mode: 0 never rises, 1 normal, 2 rises and sticks high
  task automatic run_case(input string tag, input int n, input int seed, input int init_mode,
                          input int crc_after, input int done_after, input bit poke,
                          input logic x_ok, input logic x_crc, input logic x_to);
    logic [7:0] sent[$];
    int guard;
    cur_tag = tag; rise_cnt = 0; collect_n = n; acc_cnt = 0; bitq.delete();
    for (int i = 0; i < n; i++) begin sent.push_back(pat(seed, i)); fq.push_back(pat(seed, i)); end
    @(posedge clk); #1; byte_count = CW'(n); start = 1;
    @(posedge clk); #1; start = 0;
    if (init_mode != 0) begin
      do @(posedge clk); while (!s_prog);
      repeat (3) @(posedge clk);
      #1 tgt_init = 1;
      if (init_mode == 1) begin
        do @(posedge clk); while (s_prog);
        repeat (2) @(posedge clk);
        #1 tgt_init = 0;
        if (poke) begin
          @(posedge clk); #1 start = 1;
          @(posedge clk); #1 start = 0;
        end
        if (crc_after >= 0) begin
          do @(posedge clk); while (acc_cnt < crc_after);
          #1 tgt_init = 1;
        end else if (done_after >= 0) begin
          do @(posedge clk); while (rise_cnt < 8 * n + done_after);
          #1 tgt_done = 1;
        end
      end
    end
    guard = 0;
    do begin @(posedge clk); guard++; end while (!s_end && guard < 5000);
    @(negedge clk);
    chk(tag, "load_ok", load_ok, x_ok);
    chk(tag, "crc_err", crc_err, x_crc);
    chk(tag, "timeout_err", timeout_err, x_to);
    chk(tag, "tgt_prog low after end", tgt_prog, 0);
    if (x_ok) begin
      chk(tag, "bytes accepted", acc_cnt, n);
      chk(tag, "bits shifted", bitq.size(), 8 * n);
      for (int i = 0; i < bitq.size() && i < 8 * n; i++)
        chk(tag, "MSB-first bit", bitq[i], sent[i / 8][7 - (i % 8)]);
    end
    if (x_crc) chk(tag, "no clocks after fault", rise_cnt, 8 * crc_after);
    @(posedge clk); #1 tgt_init = 0; tgt_done = 0; fq.delete();
    repeat (3) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "prog", tgt_prog, 0);  chk("R1", "cclk", tgt_cclk, 0);
    chk("R1", "din", tgt_din, 0);    chk("R1", "busy", busy, 0);
    chk("R1", "ready", in_ready, 0); chk("R1", "status", {load_end, load_ok, crc_err, timeout_err, dump_nak}, 0);
    @(posedge clk); #1 rst_n = 1;
    checking = 1;
    repeat (2) @(posedge clk);

    // R9 refusal while idle
    cur_tag = "R9";
    #1 dump_req = 1; @(posedge clk); #1 dump_req = 0;
    @(negedge clk);
    chk("R9", "dump_nak idle", dump_nak, 1);
    chk("R9", "pins untouched", {tgt_prog, tgt_cclk, tgt_din}, 0);

    run_case("R2 R4 R5 R6 R8 normal", 3, 1, 1, -1, 3, 1, 1, 0, 0);
    gappy = 1;
    run_case("R5 R6 R8 gappy stream", 4, 7, 1, -1, 1, 0, 1, 0, 0);
    gappy = 0;
    run_case("R7 crc fault", 4, 3, 1, 2, -1, 0, 0, 1, 0);
    // R10 status stays set while idle
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R10", "crc_err sticky", crc_err, 1);
    run_case("R3 init never rises", 2, 5, 0, -1, -1, 0, 0, 0, 1);
    run_case("R3 init stuck high", 2, 5, 2, -1, -1, 0, 0, 0, 1);
    run_case("R3 R8 done never rises", 1, 9, 1, -1, -1, 0, 0, 0, 1);
    run_case("R11 zero bytes", 0, 2, 1, -1, 1, 0, 1, 0, 0);
    run_case("R10 clear on restart", 2, 11, 1, -1, 2, 0, 1, 0, 0);

    // R9 refusal during a load leaves the load intact
    fork
      run_case("R9 dump during load", 2, 13, 1, -1, 2, 0, 1, 0, 0);
      begin
        repeat (30) @(posedge clk);
        #1 dump_req = 1; @(posedge clk); #1 dump_req = 0;
      end
    join

    checking = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule